// File: doc/BRIEF.md
# Island ID address decoder

This block works out which island a bus address will reach once a configured translation mode is applied. A request supplies a 40-bit address, a mode number, a flag that selects 40-bit or 32-bit addressing, two 6-bit base island numbers and a target class code. One clock later the block returns the island number, or an error when the request cannot be decoded.

The island comes from one of two sources. In the field mode it is a plain 6-bit slice of the address. In the three indexed modes a single index bit picks one of the two base islands. Zero, one or two low bits of that base are then cleared and replaced by the address bits just below the index bit. Where the index bit and the field sit depends on the addressing width.

Top module: `islDecTop`

## Requirements
- R1: Mode 0 returns address bits [39:34] when the 40-bit flag is set and bits [31:26] when it is clear.
- R2: Mode 1 uses address bit 39 (40-bit) or bit 31 (32-bit) as the index bit. A set index bit returns base island 1 and a clear one returns base island 0.
- R3: Mode 2 clears bit 0 of the selected base island and puts in its place the address bit one below the index bit (bit 38 or bit 30).
- R4: Mode 3 clears bits [1:0] of the selected base island and puts in their place the two address bits below the index bit (bits [38:37] or bits [30:29]), the higher address bit landing in island bit 1.
- R5: A request whose target class code equals the memory-unit class (default 7) or the peripheral-bus class (default 14) sets the error flag, whatever the mode.
- R6: A mode value from 4 to 7 sets the error flag.
- R7: outValid is high exactly in the cycle after a cycle with reqValid high, and the island and error outputs for that request appear in that same cycle.
- R8: When the error flag is set, outIsland is zero.
- R9: A synchronous active-high reset clears outValid, outError and outIsland.
- R10: While reqValid is low, outIsland and outError keep the values of the last accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 40 | Bus address to decode |
| reqMode | input | 3 | Translation mode; 0 to 3 are valid |
| reqWide | input | 1 | 1 selects 40-bit addressing, 0 selects 32-bit |
| baseIsl0 | input | 6 | Island chosen when the index bit is clear |
| baseIsl1 | input | 6 | Island chosen when the index bit is set |
| reqClass | input | 4 | Target class code |
| outValid | output | 1 | Result valid |
| outIsland | output | 6 | Decoded island, zero on error |
| outError | output | 1 | Request could not be decoded |

## Verification
The hardest case to reach is a mode 3 result in which the base-island bits and the address bits both contribute and each of the two index positions is exercised. This means bases with nonzero low bits, which must be masked, combined with address bits that differ from those low bits. Directed requests use base values 0x3F and 0x15 against address patterns with alternating bits around bits 39 and 31. Random requests draw every field independently, so all mode, width and class combinations occur. Idle cycles and a reset in the middle of a run test that results are held and that reset clears them.

// File: rtl/islDecPkg.sv
package islDecPkg;

  typedef enum logic [1:0] {
    PICK_FIELD = 2'd0,
    PICK_WHOLE = 2'd1,
    PICK_MIX1  = 2'd2,
    PICK_MIX2  = 2'd3
  } pickT;

  typedef struct packed {
    logic capture;
    logic fault;
    pickT pick;
  } strobeT;

endpackage

// File: rtl/islDecCtrl.sv
module islDecCtrl
  import islDecPkg::*;
#(
  parameter int MODE_W    = 3,
  parameter int CLS_W     = 4,
  parameter int MEM_CLASS = 7,
  parameter int PER_CLASS = 14
) (
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [CLS_W-1:0]  reqClass,
  output strobeT            strobe
);
  localparam logic [CLS_W-1:0]  MemCode  = CLS_W'(MEM_CLASS);
  localparam logic [CLS_W-1:0]  PerCode  = CLS_W'(PER_CLASS);
  localparam logic [MODE_W-1:0] LastMode = MODE_W'(3);

  logic badClass;
  logic badMode;

  always_comb begin
    badClass = (reqClass == MemCode) || (reqClass == PerCode);
    badMode  = (reqMode > LastMode);
    strobe.capture = reqValid;
    strobe.fault   = badClass || badMode;
    strobe.pick    = pickT'(reqMode[1:0]);
  end
endmodule

// File: rtl/islDecPath.sv
module islDecPath
  import islDecPkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int ISL_W    = 6,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWide,
  input  logic [ISL_W-1:0]  baseIsl0,
  input  logic [ISL_W-1:0]  baseIsl1,
  output logic              outValid,
  output logic [ISL_W-1:0]  outIsland,
  output logic              outError
);
  localparam int IdxWide   = ADDR_W - 1;
  localparam int IdxNarrow = NARROW_W - 1;
  localparam int FldWide   = ADDR_W - ISL_W;
  localparam int FldNarrow = NARROW_W - ISL_W;

  logic             idxBit;
  logic [1:0]       lowBits;
  logic [ISL_W-1:0] fieldVal;
  logic [ISL_W-1:0] baseSel;
  logic [ISL_W-1:0] islandNext;

  always_comb begin
    if (reqWide) begin
      idxBit   = reqAddr[IdxWide];
      lowBits  = reqAddr[IdxWide-1 -: 2];
      fieldVal = reqAddr[FldWide +: ISL_W];
    end else begin
      idxBit   = reqAddr[IdxNarrow];
      lowBits  = reqAddr[IdxNarrow-1 -: 2];
      fieldVal = reqAddr[FldNarrow +: ISL_W];
    end
    baseSel = idxBit ? baseIsl1 : baseIsl0;
    unique case (strobe.pick)
      PICK_FIELD: islandNext = fieldVal;
      PICK_WHOLE: islandNext = baseSel;
      PICK_MIX1:  islandNext = {baseSel[ISL_W-1:1], lowBits[1]};
      default:    islandNext = {baseSel[ISL_W-1:2], lowBits};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outError  <= 1'b0;
      outIsland <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outError  <= strobe.fault;
        outIsland <= strobe.fault ? '0 : islandNext;
      end
    end
  end
endmodule

// File: rtl/islDecTop.sv
module islDecTop
  import islDecPkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NARROW_W  = 32,
  parameter int ISL_W     = 6,
  parameter int MODE_W    = 3,
  parameter int CLS_W     = 4,
  parameter int MEM_CLASS = 7,
  parameter int PER_CLASS = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              reqWide,
  input  logic [ISL_W-1:0]  baseIsl0,
  input  logic [ISL_W-1:0]  baseIsl1,
  input  logic [CLS_W-1:0]  reqClass,
  output logic              outValid,
  output logic [ISL_W-1:0]  outIsland,
  output logic              outError
);
  strobeT strobe;

  islDecCtrl #(
    .MODE_W(MODE_W), .CLS_W(CLS_W), .MEM_CLASS(MEM_CLASS), .PER_CLASS(PER_CLASS)
  ) ctrl_i (
    .reqValid(reqValid), .reqMode(reqMode), .reqClass(reqClass), .strobe(strobe)
  );

  islDecPath #(
    .ADDR_W(ADDR_W), .ISL_W(ISL_W), .NARROW_W(NARROW_W)
  ) path_i (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr), .reqWide(reqWide),
    .baseIsl0(baseIsl0), .baseIsl1(baseIsl1),
    .outValid(outValid), .outIsland(outIsland), .outError(outError)
  );
endmodule

// File: rtl/islDecChecker.sv
module islDecChecker #(
  parameter int ADDR_W    = 40,
  parameter int NARROW_W  = 32,
  parameter int ISL_W     = 6,
  parameter int MODE_W    = 3,
  parameter int CLS_W     = 4,
  parameter int MEM_CLASS = 7,
  parameter int PER_CLASS = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [MODE_W-1:0] reqMode,
  input logic              reqWide,
  input logic [ISL_W-1:0]  baseIsl0,
  input logic [ISL_W-1:0]  baseIsl1,
  input logic [CLS_W-1:0]  reqClass,
  input logic              outValid,
  input logic [ISL_W-1:0]  outIsland,
  input logic              outError
);
  localparam int FldWide = ADDR_W - ISL_W;
  localparam int IdxWide = ADDR_W - 1;

  logic classBad;
  assign classBad = (reqClass == CLS_W'(MEM_CLASS)) || (reqClass == CLS_W'(PER_CLASS));

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> outValid);
  assert_valid_drops_R7: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !outValid);
  assert_error_zero_R8: assert property (@(posedge clk) disable iff (rst)
    outError |-> (outIsland == '0));
  assert_class_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && classBad) |=> outError);
  assert_mode_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqMode > MODE_W'(3)) |=> outError);
  assert_field_wide_R1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !classBad && reqMode == '0 && reqWide)
      |=> (outIsland == $past(reqAddr[FldWide +: ISL_W])));
  assert_base_wide_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !classBad && reqMode == MODE_W'(1) && reqWide && reqAddr[IdxWide])
      |=> (outIsland == $past(baseIsl1)));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> ($stable(outIsland) && $stable(outError)));
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!outValid && !outError && outIsland == '0));
endmodule

bind islDecTop islDecChecker #(
  .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .ISL_W(ISL_W), .MODE_W(MODE_W),
  .CLS_W(CLS_W), .MEM_CLASS(MEM_CLASS), .PER_CLASS(PER_CLASS)
) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqMode(reqMode),
  .reqWide(reqWide), .baseIsl0(baseIsl0), .baseIsl1(baseIsl1), .reqClass(reqClass),
  .outValid(outValid), .outIsland(outIsland), .outError(outError)
);

// File: tb/islDecTop_tb_top.sv
`timescale 1ns/1ps
module islDecTop_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [39:0] reqAddr;
  logic [2:0]  reqMode;
  logic        reqWide;
  logic [5:0]  baseIsl0;
  logic [5:0]  baseIsl1;
  logic [3:0]  reqClass;
  logic        outValid;
  logic [5:0]  outIsland;
  logic        outError;

  int checkCount = 0;
  int failCount  = 0;
  logic       expValid = 1'b0;
  logic       expErr   = 1'b0;
  logic [5:0] expIsl   = '0;
  string      lastTag  = "R9";

  always #10 clk = ~clk;

  islDecTop dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqMode(reqMode),
    .reqWide(reqWide), .baseIsl0(baseIsl0), .baseIsl1(baseIsl1), .reqClass(reqClass),
    .outValid(outValid), .outIsland(outIsland), .outError(outError)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model of the decode rules.
  task automatic model(input logic [39:0] a, input int m, input logic w,
                       input int b0, input int b1, input int c,
                       output logic [5:0] isl, output logic err, output string tag);
    longint unsigned av = longint'(a);
    int idx = w ? 39 : 31;
    int fld = w ? 34 : 26;
    int sel = ((av >> idx) & 1) != 0 ? b1 : b0;
    err = 1'b0; isl = '0;
    if (c == 7 || c == 14) begin err = 1'b1; tag = "R5"; end
    else if (m > 3) begin err = 1'b1; tag = "R6"; end
    else if (m == 0) begin isl = 6'((av >> fld) & 63); tag = "R1"; end
    else if (m == 1) begin isl = 6'(sel); tag = "R2"; end
    else if (m == 2) begin isl = 6'((sel & 62) | int'((av >> (idx-1)) & 1)); tag = "R3"; end
    else begin isl = 6'((sel & 60) | int'((av >> (idx-2)) & 3)); tag = "R4"; end
  endtask

  task automatic step(input logic v, input logic [39:0] a, input int m, input logic w,
                      input int b0, input int b1, input int c);
    logic [5:0] isl; logic err; string tag;
    reqValid = v; reqAddr = a; reqMode = 3'(m); reqWide = w;
    baseIsl0 = 6'(b0); baseIsl1 = 6'(b1); reqClass = 4'(c);
    model(a, m, w, b0, b1, c, isl, err, tag);
    expValid = v;
    if (v) begin expIsl = isl; expErr = err; lastTag = tag; end
    else lastTag = "R10";
    @(negedge clk);
    check("R7 outValid", {7'd0, outValid}, {7'd0, expValid});
    check(lastTag, {1'b0, outError, outIsland}, {1'b0, expErr, expIsl});
    if (expErr) check("R8 island zero on error", {2'd0, outIsland}, 8'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; reqValid = 1'b0; reqAddr = '0; reqMode = '0; reqWide = 1'b0;
    baseIsl0 = '0; baseIsl1 = '0; reqClass = '0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {7'd0, outValid}, 8'd0);
    check("R9 reset error/island", {1'b0, outError, outIsland}, 8'd0);
    rst = 1'b0;

    // R1 field mode, both widths
    step(1, 40'hA5_F3C0_0000, 0, 1, 5, 9, 0);
    step(1, 40'h00_5C00_0000, 0, 0, 5, 9, 0);
    // R2 index bit selects base
    step(1, 40'h80_0000_0000, 1, 1, 12, 33, 1);
    step(1, 40'h7F_FFFF_FFFF, 1, 1, 12, 33, 1);
    step(1, 40'h00_8000_0000, 1, 0, 12, 33, 2);
    step(1, 40'hFF_7FFF_FFFF, 1, 0, 12, 33, 2);
    // R3 one low bit
    step(1, 40'hC0_0000_0000, 2, 1, 21, 63, 3);
    step(1, 40'h40_0000_0000, 2, 1, 21, 63, 3);
    step(1, 40'h00_4000_0000, 2, 0, 21, 63, 3);
    // R4 two low bits, masked bases
    step(1, 40'hA0_0000_0000, 3, 1, 21, 63, 4);
    step(1, 40'h2A_AAAA_AAAA, 3, 1, 63, 21, 4);
    step(1, 40'h00_A000_0000, 3, 0, 21, 63, 4);
    step(1, 40'hFF_5FFF_FFFF, 3, 0, 63, 21, 4);
    // R5 rejected classes in every mode
    step(1, 40'hFF_FFFF_FFFF, 0, 1, 63, 63, 7);
    step(1, 40'hFF_FFFF_FFFF, 3, 0, 63, 63, 14);
    // R6 bad modes
    step(1, 40'hFF_FFFF_FFFF, 4, 1, 63, 63, 0);
    step(1, 40'hFF_FFFF_FFFF, 7, 0, 63, 63, 0);
    // R10 idle with changing inputs keeps result
    step(1, 40'h80_0000_0000, 1, 1, 3, 44, 0);
    step(0, 40'h00_0000_0000, 1, 1, 9, 9, 7);
    step(0, 40'hFF_FFFF_FFFF, 5, 0, 1, 2, 0);

    for (int i = 0; i < 400; i++) begin
      logic [39:0] a = {8'($urandom), 32'($urandom)};
      step(($urandom % 5) != 0, a, int'($urandom % 8), 1'($urandom),
           int'($urandom % 64), int'($urandom % 64), int'($urandom % 16));
    end

    // R9 reset in the middle of traffic
    step(1, 40'hFF_FFFF_FFFF, 1, 1, 63, 63, 0);
    rst = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    check("R9 mid reset valid", {7'd0, outValid}, 8'd0);
    check("R9 mid reset error/island", {1'b0, outError, outIsland}, 8'd0);
    rst = 1'b0;
    step(1, 40'h00_0400_0000, 0, 0, 0, 0, 0);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule